// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets logic on one system clock read and write an external asynchronous static RAM of 256K words by 16 bits. Each access is divided into whole clock phases, so no memory timing depends on a fraction of a cycle. A write has three phases: setup, then strobe, then hold. A read has two: address first, then output enable. A parameter can stretch the strobe phase of either access by extra wait cycles for slower parts or faster clocks.

The user side presents an address, write data, a write/read flag, a valid strobe and a select qualifier. The select qualifier says that the address belongs to this memory. When the access completes, the block returns read data and a one-cycle completion pulse. Every control, address and write-data pin is driven straight from a register. Read data is captured by edge-triggered flops. When the bus direction reverses between accesses, the controller inserts one idle cycle in which it leaves the data bus undriven.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n and mem_lb_n are high, the controller does not drive mem_dq, and rsp_done is low.
- R2: A request is taken only when req_vld and req_sel are both high while the controller is idle. With either of them low, no memory cycle starts and rsp_done stays low.
- R3: A write with W wait cycles has three parts. First comes one setup cycle with mem_we_n high and address and data driven. Then mem_we_n is low for 1+W cycles. Last comes one hold cycle with mem_we_n high and address and data unchanged. Address and data never change in a cycle where mem_we_n changes.
- R4: A read drives the address for one cycle with mem_oe_n high. It then holds mem_oe_n low for 1+W cycles. rsp_rdata takes the value on mem_dq at the clock edge that ends the last output-enable cycle.
- R5: When an access has the opposite direction to the one before it, one extra cycle with the bus idle precedes it. This makes completion one cycle later.
- R6: rsp_done is high for exactly one cycle per accepted access. Counting the acceptance edge as 0, rsp_done is high in cycle 3+W after a read and in cycle 4+W after a write, plus one with a turnaround.
- R7: The controller drives mem_dq only during the cycles of a write. mem_oe_n is never low while it drives.
- R8: Requests presented while an access is in progress are ignored. They do not write memory, they do not start a cycle after the current one, and they produce no rsp_done.
- R9: mem_ub_n and mem_lb_n are both low whenever mem_ce_n is low (full-word access).
- R10: rsp_rdata keeps its value until the next read completes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_vld | input | 1 | Address-valid strobe |
| req_sel | input | 1 | Qualifier: address targets this memory |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 18 | Memory address bus |
| mem_dq | inout | 16 | Memory data bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |

## Verification
The bench builds the controller with one wait cycle (ACT_WAIT = 1) and the default 18-bit address and 16-bit data. The wait cycle exercises the strobe-phase counter's reload and count-down paths, which a zero-wait build never reaches. A behavioural memory in the bench latches writes on the rising edge of mem_we_n and answers reads while chip and output enable are low. Because of this, both a wrong hold-cycle address and a wrong capture edge show up as data errors.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TURN  = 3'd1,
        ST_RADDR = 3'd2,
        ST_ROE   = 3'd3,
        ST_WSET  = 3'd4,
        ST_WACT  = 3'd5,
        ST_WHOLD = 3'd6
    } asram_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } asram_pins_t;

    localparam asram_pins_t PINS_OFF = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

endpackage

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ACT_WAIT = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_vld,
    input  logic req_sel,
    input  logic req_wr,
    output logic accept,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic be_n,
    output logic drv,
    output logic cap,
    output logic done
);

    localparam int CNT_W = (ACT_WAIT > 0) ? $clog2(ACT_WAIT + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACT_WAIT);

    typedef struct packed {
        asram_state_e    state;
        logic [CNT_W-1:0] cnt;
        asram_pins_t     pins;
        logic            done;
        logic            pend_wr;
        logic            last_wr;
        logic            seen;
    } seq_t;

    seq_t s_d, s_q;

    function automatic asram_pins_t first_pins(input logic wr);
        asram_pins_t p;
        p = PINS_OFF;
        p.ce_n = 1'b0;
        p.drv  = wr;
        return p;
    endfunction

    assign accept = (s_q.state == ST_IDLE) && req_vld && req_sel;
    assign cap    = (s_q.state == ST_ROE) && (s_q.cnt == '0);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (accept) begin
                    s_d.pend_wr = req_wr;
                    s_d.last_wr = req_wr;
                    s_d.seen    = 1'b1;
                    if (s_q.seen && (s_q.last_wr != req_wr)) begin
                        s_d.state = ST_TURN;
                        s_d.pins  = PINS_OFF;
                    end else begin
                        s_d.state = req_wr ? ST_WSET : ST_RADDR;
                        s_d.pins  = first_pins(req_wr);
                    end
                end
            end
            ST_TURN: begin
                s_d.state = s_q.pend_wr ? ST_WSET : ST_RADDR;
                s_d.pins  = first_pins(s_q.pend_wr);
            end
            ST_RADDR: begin
                s_d.state     = ST_ROE;
                s_d.pins.oe_n = 1'b0;
                s_d.cnt       = CNT_LOAD;
            end
            ST_ROE: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.state = ST_IDLE;
                    s_d.pins  = PINS_OFF;
                    s_d.done  = 1'b1;
                end
            end
            ST_WSET: begin
                s_d.state     = ST_WACT;
                s_d.pins.we_n = 1'b0;
                s_d.cnt       = CNT_LOAD;
            end
            ST_WACT: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.state     = ST_WHOLD;
                    s_d.pins.we_n = 1'b1;
                end
            end
            ST_WHOLD: begin
                s_d.state = ST_IDLE;
                s_d.pins  = PINS_OFF;
                s_d.done  = 1'b1;
            end
            default: begin
                s_d.state = ST_IDLE;
                s_d.pins  = PINS_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state   <= ST_IDLE;
            s_q.cnt     <= '0;
            s_q.pins    <= PINS_OFF;
            s_q.done    <= 1'b0;
            s_q.pend_wr <= 1'b0;
            s_q.last_wr <= 1'b0;
            s_q.seen    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ce_n = s_q.pins.ce_n;
    assign oe_n = s_q.pins.oe_n;
    assign we_n = s_q.pins.we_n;
    assign be_n = s_q.pins.ce_n;
    assign drv  = s_q.pins.drv;
    assign done = s_q.done;

endmodule

// File: rtl/asram_wpath.sv
module asram_wpath #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wp_t;

    wp_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (load) begin
            w_d.addr = addr_in;
            w_d.data = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign addr_out = w_q.addr;
    assign data_out = w_q.data;

endmodule

// File: rtl/asram_rcap.sv
module asram_rcap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] data_out
);

    logic [DATA_W-1:0] r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cap) begin
            r_d = bus_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_out = r_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int ACT_WAIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_sel,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n
);

    logic              accept;
    logic              be_n;
    logic              dq_drv;
    logic              cap;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] dq_in;

    asram_seq #(.ACT_WAIT(ACT_WAIT)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_vld (req_vld),
        .req_sel (req_sel),
        .req_wr  (req_wr),
        .accept  (accept),
        .ce_n    (mem_ce_n),
        .oe_n    (mem_oe_n),
        .we_n    (mem_we_n),
        .be_n    (be_n),
        .drv     (dq_drv),
        .cap     (cap),
        .done    (rsp_done)
    );

    asram_wpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .addr_in  (req_addr),
        .data_in  (req_wdata),
        .addr_out (mem_addr),
        .data_out (wdata_q)
    );

    asram_rcap #(.DATA_W(DATA_W)) u_rcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .bus_in   (dq_in),
        .data_out (rsp_rdata)
    );

    assign mem_dq   = dq_drv ? wdata_q : {DATA_W{1'bz}};
    assign dq_in    = mem_dq;
    assign mem_ub_n = be_n;
    assign mem_lb_n = be_n;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              ub_n,
    input logic              lb_n,
    input logic              drv,
    input logic              done,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata
);

    AST_WE_FALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> ($stable(addr) && $stable(wdata) && drv && $past(drv))); // R3
    AST_WE_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> ($stable(addr) && $stable(wdata) && drv && !ce_n)); // R3
    AST_OE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> ($past(!ce_n) && $stable(addr))); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        drv |-> (oe_n && !ce_n)); // R7
    AST_WE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> drv); // R7
    AST_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> (!ub_n && !lb_n)); // R9
    AST_RDATA_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> $stable(rdata)); // R10

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_asram_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (mem_ce_n),
    .oe_n  (mem_oe_n),
    .we_n  (mem_we_n),
    .ub_n  (mem_ub_n),
    .lb_n  (mem_lb_n),
    .drv   (dq_drv),
    .done  (rsp_done),
    .addr  (mem_addr),
    .wdata (wdata_q),
    .rdata (rsp_rdata)
);

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;

    localparam int AW = 18;
    localparam int DW = 16;
    localparam int W  = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_vld = 1'b0, req_sel = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] mem_dq;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACT_WAIT(W)) i_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_sel(req_sel),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
        .mem_dq(mem_dq), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n)
    );

    // behavioural asynchronous memory
    logic [DW-1:0] mem [logic [AW-1:0]];
    logic [DW-1:0] mdrv;

    function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
        return mem.exists(a) ? mem[a] : 16'hBEEF;
    endfunction

    always @* mdrv = mem_rd(mem_addr);
    assign mem_dq = (!mem_ce_n && !mem_oe_n) ? mdrv : {DW{1'bz}};

    always @(posedge mem_we_n) begin
        if (rst_n && mem_ce_n == 1'b0) mem[mem_addr] = mem_dq;
    end

    // bench shadow of what the memory must contain
    logic [DW-1:0] shadow [logic [AW-1:0]];
    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        return shadow.exists(a) ? shadow[a] : 16'hBEEF;
    endfunction

    function automatic int exp_latency(input logic wr, input bit turn);
        return (wr ? 4 + W : 3 + W) + (turn ? 1 : 0);
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, expv, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    bit            have_prev = 0;
    logic          prev_wr   = 0;
    logic [DW-1:0] last_rdata = '0;

    task automatic access(input logic wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit inj_busy);
        int            lat;
        int            k;
        bit            turn;
        logic [AW-1:0] a2;
        logic [DW-1:0] before2;
        turn = have_prev && (prev_wr != wr);
        lat  = exp_latency(wr, turn);
        a2   = a ^ 18'h00001;
        before2 = mem_rd(a2);
        @(negedge clk);
        req_vld = 1; req_sel = 1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_vld = 0; req_sel = 0;
        k = 1;
        while (rsp_done !== 1'b1 && k < 30) begin
            int ph;
            ph = k - (turn ? 1 : 0);
            if (wr) begin
                if (ph == 1) check(mem_we_n === 1'b1 && mem_dq === d && mem_addr === a,
                                   "R3 setup", {mem_we_n, mem_dq}, {1'b1, d});
                if (ph == 2) check(mem_we_n === 1'b0, "R3 strobe", mem_we_n, 0);
                if (ph == 3 + W) check(mem_we_n === 1'b1 && mem_dq === d && mem_addr === a,
                                       "R3 hold", {mem_we_n, mem_dq}, {1'b1, d});
            end else begin
                if (ph == 1) check(mem_oe_n === 1'b1 && mem_ce_n === 1'b0 && mem_addr === a,
                                   "R4 address phase", mem_oe_n, 1);
                if (ph == 2) check(mem_oe_n === 1'b0, "R4 output enable", mem_oe_n, 0);
            end
            if (turn && k == 1) check(mem_ce_n === 1'b1 && mem_oe_n === 1'b1 && mem_we_n === 1'b1,
                                      "R5 turnaround idle", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
            if (inj_busy && k == 2) begin
                req_vld = 1; req_sel = 1; req_wr = 1; req_addr = a2; req_wdata = ~d;
            end else begin
                req_vld = 0; req_sel = 0;
            end
            @(negedge clk);
            k++;
        end
        req_vld = 0; req_sel = 0;
        check(k == lat, turn ? "R5 turnaround latency" : "R6 done latency", k, lat);
        if (wr) begin
            shadow[a] = d;
            check(mem_rd(a) === d, "R3 memory written", mem_rd(a), d);
            check(rsp_rdata === last_rdata, "R10 rdata kept over write", rsp_rdata, last_rdata);
        end else begin
            check(rsp_rdata === exp_rd(a), "R4 read data", rsp_rdata, exp_rd(a));
            last_rdata = exp_rd(a);
        end
        have_prev = 1; prev_wr = wr;
        @(negedge clk);
        check(rsp_done === 1'b0, "R6 single pulse", rsp_done, 0);
        if (inj_busy) begin
            for (int i = 0; i < 3; i++) begin
                check(mem_ce_n === 1'b1 && rsp_done === 1'b0, "R8 busy request ignored",
                      {mem_ce_n, rsp_done}, 2'b10);
                @(negedge clk);
            end
            check(mem_rd(a2) === before2, "R8 no stray write", mem_rd(a2), before2);
        end
    endtask

    logic [AW-1:0] pool [16];

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(mem_ce_n === 1 && mem_oe_n === 1 && mem_we_n === 1 && mem_ub_n === 1 &&
              mem_lb_n === 1 && rsp_done === 0, "R1 reset outputs",
              {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, rsp_done}, 6'b111110);
        rst_n = 1;
        @(negedge clk);
        check(mem_ce_n === 1 && rsp_done === 0, "R1 idle after reset", {mem_ce_n, rsp_done}, 2'b10);

        // R2: strobe without qualifier, qualifier without strobe
        req_vld = 1; req_sel = 0; req_wr = 1; req_addr = 18'h00100; req_wdata = 16'h1111;
        repeat (3) begin
            @(negedge clk);
            check(mem_ce_n === 1 && rsp_done === 0, "R2 no select", {mem_ce_n, rsp_done}, 2'b10);
        end
        req_vld = 0; req_sel = 1;
        repeat (3) begin
            @(negedge clk);
            check(mem_ce_n === 1 && rsp_done === 0, "R2 no valid", {mem_ce_n, rsp_done}, 2'b10);
        end
        req_sel = 0;
        check(!mem.exists(18'h00100), "R2 nothing written", mem.exists(18'h00100), 0);

        // directed corners
        access(1'b1, 18'h3FFFF, 16'hFFFF, 0);
        access(1'b1, 18'h00000, 16'h0000, 0);
        access(1'b0, 18'h3FFFF, 16'h0, 0);
        access(1'b0, 18'h00000, 16'h0, 0);
        access(1'b1, 18'h2AAAA, 16'hA5A5, 1);
        access(1'b0, 18'h2AAAA, 16'h0, 1);
        access(1'b0, 18'h15555, 16'h0, 0);
        access(1'b1, 18'h15555, 16'h5A5A, 0);

        for (int i = 0; i < 16; i++) pool[i] = AW'($urandom);
        for (int i = 0; i < 200; i++) begin
            logic          wr;
            logic [AW-1:0] a;
            wr = 1'($urandom);
            a  = pool[$urandom % 16];
            access(wr, a, DW'($urandom), ($urandom % 8) == 0);
            if (($urandom % 4) == 0) repeat ($urandom % 3) @(negedge clk);
        end

        summary();
        $finish;
    end

endmodule